// File: doc/BRIEF.md
# Folding-Integration Coarse/Fine ADC Sequencer

This block drives the phase controls of a column converter whose single analog core first acts as a folding integrator and then acts as a cyclic converter. A conversion begins with a clear cycle that empties the integrator. Then come 2^m integration cycles. In each one the input is added, and a reference is removed whenever the threshold decision of the previous cycle was 1. The number of 1 decisions becomes the coarse code. One handoff cycle applies any subtraction still owed by the last decision and switches the core to cyclic mode. The cyclic phase then delivers FINE_BITS residue bits, most significant first.

When the last residue bit arrives, the coarse count and the fine code are merged with a one-bit overlap and registered, and a single-cycle done strobe is raised. The coarse counter saturates at 2^m − 1. A saturated result is marked by an overflow flag that is registered with the code. The states are IDLE, CLEAR, INTEG, HANDOFF, CYCLIC and DONE, and the transitions are:
- IDLE→CLEAR on start.
- CLEAR→INTEG after one cycle.
- INTEG→HANDOFF after 2^m cycles.
- HANDOFF→CYCLIC after one cycle.
- CYCLIC→DONE after FINE_BITS cycles.
- DONE→IDLE after one cycle.

Top module: `fic_seq`

## Requirements
- R1: During and right after reset, all phase controls (int_clr, int_en, ref_sub, cyc_en) and done are low, code is 0 and overflow is 0.
- R2: Start seen in IDLE causes exactly one int_clr cycle, which is followed at once by exactly 2^m consecutive int_en cycles.
- R3: ref_sub is high in an integration cycle, or in the handoff cycle just after the last one, exactly when the cmp_bit sampled at the end of the previous integration cycle was 1. It is never high in the first integration cycle.
- R4: The coarse code equals the number of integration cycles that ended with cmp_bit = 1, saturated at 2^m − 1. overflow is 1 in a result exactly when the count would have exceeded 2^m − 1.
- R5: m is taken from cfg_mbits at start. A value of 0 is treated as 1, and a value above MBITS_MAX is treated as MBITS_MAX. Changes during a conversion have no effect.
- R6: One cycle after the last integration cycle, cyc_en is high for exactly FINE_BITS cycles. fine_bit is sampled at the end of each of these cycles, and the first sample is the MSB.
- R7: code = (coarse << (FINE_BITS−1)) + fine. It updates only in the done cycle and holds until the next done.
- R8: done is a one-cycle pulse in the cycle right after the last cyc_en cycle.
- R9: start is ignored while a conversion is in progress.
- R10: At most one of int_clr, int_en, cyc_en and done is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a conversion |
| cfg_mbits | input | $clog2(MBITS_MAX+1) | Coarse resolution m in bits |
| cmp_bit | input | 1 | Threshold comparator decision |
| fine_bit | input | 1 | Cyclic residue bit stream |
| int_clr | output | 1 | Clear the integrator |
| int_en | output | 1 | Integrate the input this cycle |
| ref_sub | output | 1 | Subtract the reference this cycle |
| cyc_en | output | 1 | Core in cyclic mode, one bit step |
| done | output | 1 | Result valid strobe |
| code | output | MBITS_MAX+FINE_BITS | Combined coarse/fine code |
| overflow | output | 1 | Coarse count saturated |

## Verification
The bench builds the block with its default parameters, MBITS_MAX = 7 and FINE_BITS = 13, so the full 20-bit result width is exercised. It covers m from the clamped value of 1 up to 7, so integration runs from 2 to 128 cycles. An integer model of the integrator produces the comparator decisions, which lets the bench reach three cases: zero input, a sparse fold count, and all decisions at 1 that saturate the counter. Extra start pulses and configuration changes are issued during a conversion.

// File: rtl/fic_pkg.sv
package fic_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_INTEG,
        ST_HANDOFF,
        ST_CYCLIC,
        ST_DONE
    } fic_state_t;

    function automatic int fic_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fic_phase_fsm.sv
module fic_phase_fsm #(
    parameter int MBITS_MAX = 7,
    parameter int FINE_BITS = 13,
    localparam int CFG_W = $clog2(MBITS_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CFG_W-1:0] cfg_mbits,
    output logic [CFG_W-1:0] m_sel,
    output logic             int_clr,
    output logic             int_en,
    output logic             handoff,
    output logic             cyc_en,
    output logic             last_fine,
    output logic             done_st
);
    import fic_pkg::*;

    localparam int CNT_W = fic_max(MBITS_MAX + 1, $clog2(FINE_BITS) + 1);
    localparam logic [CNT_W-1:0] FINE_LAST = CNT_W'(FINE_BITS - 1);

    fic_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CFG_W-1:0] m_q;
    logic [CFG_W-1:0] m_clamp;
    logic [CNT_W-1:0] integ_last;

    // coarse resolution clamp: 0 -> 1, above maximum -> maximum
    always_comb begin
        if (cfg_mbits == '0) begin
            m_clamp = CFG_W'(1);
        end else if (32'(cfg_mbits) > MBITS_MAX) begin
            m_clamp = CFG_W'(MBITS_MAX);
        end else begin
            m_clamp = cfg_mbits;
        end
    end

    assign integ_last = (CNT_W'(1) << m_q) - CNT_W'(1);
    assign m_sel      = m_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_CLEAR;
            ST_CLEAR:   state_d = ST_INTEG;
            ST_INTEG:   if (cnt_q == integ_last) state_d = ST_HANDOFF;
            ST_HANDOFF: state_d = ST_CYCLIC;
            ST_CYCLIC:  if (cnt_q == FINE_LAST) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register, phase counter and latched configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            m_q     <= CFG_W'(1);
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (state_q == ST_INTEG || state_q == ST_CYCLIC) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (state_q == ST_IDLE && start) begin
                m_q <= m_clamp;
            end
        end
    end

    // phase outputs
    always_comb begin
        int_clr   = 1'b0;
        int_en    = 1'b0;
        handoff   = 1'b0;
        cyc_en    = 1'b0;
        last_fine = 1'b0;
        done_st   = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_CLEAR:   int_clr = 1'b1;
            ST_INTEG:   int_en = 1'b1;
            ST_HANDOFF: handoff = 1'b1;
            ST_CYCLIC: begin
                cyc_en    = 1'b1;
                last_fine = (cnt_q == FINE_LAST);
            end
            ST_DONE:    done_st = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/fic_fold_count.sv
module fic_fold_count #(
    parameter int MBITS_MAX = 7,
    localparam int CFG_W = $clog2(MBITS_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 int_en,
    input  logic                 handoff,
    input  logic                 cmp_bit,
    input  logic [CFG_W-1:0]     m_sel,
    output logic [MBITS_MAX-1:0] coarse,
    output logic                 ovf,
    output logic                 ref_sub
);
    logic [MBITS_MAX-1:0] cnt_q;
    logic                 ovf_q;
    logic                 d_prev_q;
    logic [MBITS_MAX-1:0] lim;

    // saturation limit 2^m - 1
    assign lim = {MBITS_MAX{1'b1}} >> (MBITS_MAX - int'(m_sel));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            ovf_q    <= 1'b0;
            d_prev_q <= 1'b0;
        end else if (clr) begin
            cnt_q    <= '0;
            ovf_q    <= 1'b0;
            d_prev_q <= 1'b0;
        end else if (int_en) begin
            d_prev_q <= cmp_bit;
            if (cmp_bit) begin
                if (cnt_q == lim) begin
                    ovf_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // reference removal follows the previous decision
    assign ref_sub = d_prev_q & (int_en | handoff);
    assign coarse  = cnt_q;
    assign ovf     = ovf_q;

endmodule

// File: rtl/fic_fine_shift.sv
module fic_fine_shift #(
    parameter int FINE_BITS = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 shift_en,
    input  logic                 bit_in,
    output logic [FINE_BITS-1:0] fine_next
);
    logic [FINE_BITS-2:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (clr) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= fine_next[FINE_BITS-2:0];
        end
    end

    // word including the bit presented this cycle (MSB first)
    assign fine_next = {sr_q, bit_in};

endmodule

// File: rtl/fic_seq.sv
module fic_seq #(
    parameter int MBITS_MAX = 7,
    parameter int FINE_BITS = 13,
    localparam int CFG_W  = $clog2(MBITS_MAX + 1),
    localparam int CODE_W = MBITS_MAX + FINE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CFG_W-1:0]  cfg_mbits,
    input  logic              cmp_bit,
    input  logic              fine_bit,
    output logic              int_clr,
    output logic              int_en,
    output logic              ref_sub,
    output logic              cyc_en,
    output logic              done,
    output logic [CODE_W-1:0] code,
    output logic              overflow
);
    logic [CFG_W-1:0]     m_sel;
    logic                 handoff;
    logic                 last_fine;
    logic                 done_st;
    logic [MBITS_MAX-1:0] coarse;
    logic                 ovf;
    logic [FINE_BITS-1:0] fine_next;
    logic [CODE_W-1:0]    code_q;
    logic                 ovf_q;

    fic_phase_fsm #(
        .MBITS_MAX (MBITS_MAX),
        .FINE_BITS (FINE_BITS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_mbits (cfg_mbits),
        .m_sel     (m_sel),
        .int_clr   (int_clr),
        .int_en    (int_en),
        .handoff   (handoff),
        .cyc_en    (cyc_en),
        .last_fine (last_fine),
        .done_st   (done_st)
    );

    fic_fold_count #(
        .MBITS_MAX (MBITS_MAX)
    ) u_fold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (int_clr),
        .int_en  (int_en),
        .handoff (handoff),
        .cmp_bit (cmp_bit),
        .m_sel   (m_sel),
        .coarse  (coarse),
        .ovf     (ovf),
        .ref_sub (ref_sub)
    );

    fic_fine_shift #(
        .FINE_BITS (FINE_BITS)
    ) u_fine (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (int_clr),
        .shift_en  (cyc_en),
        .bit_in    (fine_bit),
        .fine_next (fine_next)
    );

    // merge with one bit of overlap, registered on the last fine step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            ovf_q  <= 1'b0;
        end else if (last_fine) begin
            code_q <= (CODE_W'(coarse) << (FINE_BITS - 1)) + CODE_W'(fine_next);
            ovf_q  <= ovf;
        end
    end

    assign code     = code_q;
    assign overflow = ovf_q;
    assign done     = done_st;

endmodule

// File: rtl/fic_seq_chk.sv
module fic_seq_chk #(
    parameter int CODE_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_bit,
    input logic              int_clr,
    input logic              int_en,
    input logic              ref_sub,
    input logic              cyc_en,
    input logic              done,
    input logic [CODE_W-1:0] code,
    input logic              overflow
);
    assert_phase_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_clr, int_en, cyc_en, done}));

    assert_clear_then_integ_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int_clr |=> int_en);

    assert_first_integ_nosub_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_en) |-> !ref_sub);

    assert_sub_after_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_sub |-> ($past(int_en) && $past(cmp_bit)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_cyclic_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cyc_en));

    assert_code_moves_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code) |-> done);

    assert_ovf_moves_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(overflow) |-> done);

endmodule

bind fic_seq fic_seq_chk #(.CODE_W(MBITS_MAX + FINE_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_bit  (cmp_bit),
    .int_clr  (int_clr),
    .int_en   (int_en),
    .ref_sub  (ref_sub),
    .cyc_en   (cyc_en),
    .done     (done),
    .code     (code),
    .overflow (overflow)
);

// File: tb/tb_fic_seq.sv
module tb_fic_seq;
    localparam int MBITS_MAX = 7;
    localparam int FINE_BITS = 13;
    localparam int CFG_W  = $clog2(MBITS_MAX + 1);
    localparam int CODE_W = MBITS_MAX + FINE_BITS;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              ovf;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CFG_W-1:0]  cfg_mbits = '0;
    logic              cmp_bit = 1'b0;
    logic              fine_bit = 1'b0;
    logic              int_clr, int_en, ref_sub, cyc_en, done, overflow;
    logic [CODE_W-1:0] code;

    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;
    exp_t q[$];
    exp_t last_exp = '0;

    always #4 clk = ~clk;

    fic_seq #(.MBITS_MAX(MBITS_MAX), .FINE_BITS(FINE_BITS)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mbits(cfg_mbits),
        .cmp_bit(cmp_bit), .fine_bit(fine_bit), .int_clr(int_clr),
        .int_en(int_en), .ref_sub(ref_sub), .cyc_en(cyc_en), .done(done),
        .code(code), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compare each done result against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (q.size() == 0) begin
                    check(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(code == e.code, "R7 code", code, e.code);
                    check(overflow == e.ovf, "R4 overflow", overflow, e.ovf);
                end
            end
        end
    end

    // driver: predicts the result, then runs the integrator model against the DUT
    task automatic run_conv(input int m_cfg, input int vin, input int vr, input int vt,
                            input int fine_val, input bit extra_start, input int m_late);
        int eff_m, s, vo, ones, lim, n_int, n_fine, n_hand;
        bit dprev, d;
        exp_t e;
        eff_m = (m_cfg == 0) ? 1 : ((m_cfg > MBITS_MAX) ? MBITS_MAX : m_cfg);
        s = 1 << eff_m;
        lim = s - 1;
        vo = 0; ones = 0; dprev = 1'b0;
        for (int i = 0; i < s; i++) begin
            vo = vo + vin - (dprev ? vr : 0);
            d = (vo >= vt);
            ones += int'(d);
            dprev = d;
        end
        e.ovf  = (ones > lim);
        e.code = (CODE_W'((ones > lim) ? lim : ones) << (FINE_BITS - 1)) + CODE_W'(fine_val);
        q.push_back(e);

        @(negedge clk);
        cfg_mbits = CFG_W'(m_cfg);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cfg_mbits = CFG_W'(m_late);   // R5: ignored once started
        check(int_clr == 1'b1, "R2 clear cycle", int_clr, 1);

        vo = 0; dprev = 1'b0; n_int = 0; n_fine = 0; n_hand = 0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (done) break;
            if (int_en) begin
                check(ref_sub == dprev, "R3 ref_sub in integration", ref_sub, dprev);
                vo = vo + vin - (dprev ? vr : 0);
                d = (vo >= vt);
                cmp_bit = d;
                dprev = d;
                n_int++;
                if (extra_start && n_int == 2) start = 1'b1;   // R9
            end else if (ref_sub) begin
                n_hand++;
            end
            if (cyc_en) begin
                if (n_fine == 0) begin
                    check(n_hand == int'(dprev), "R3 handoff subtraction", n_hand, dprev);
                end
                fine_bit = fine_val[FINE_BITS - 1 - n_fine];
                n_fine++;
            end
        end
        check(n_int == s, "R2/R5 integration length", n_int, s);
        check(n_fine == FINE_BITS, "R6 cyclic length", n_fine, FINE_BITS);
        last_exp = e;
        @(negedge clk);
        check(done == 1'b0, "R8 done single cycle", done, 0);
        check(int_clr == 1'b0, "R9 no restart", int_clr, 0);
        repeat (3) @(negedge clk);
        check(code == last_exp.code, "R7 code held", code, last_exp.code);
        check({int_clr, int_en, cyc_en, done} == 4'b0, "R10 idle phases", {int_clr, int_en, cyc_en, done}, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check({int_clr, int_en, ref_sub, cyc_en, done} == 5'b0, "R1 controls in reset",
              {int_clr, int_en, ref_sub, cyc_en, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(code == '0, "R1 code after reset", code, 0);
        check(overflow == 1'b0, "R1 overflow after reset", overflow, 0);

        run_conv(3, 30, 100, 100, 13'h0A5A, 1'b0, 3);    // R4 sparse folds
        run_conv(1, 70, 100, 100, 13'h1001, 1'b0, 1);    // R4 reaches limit, no overflow
        run_conv(2, 100, 100, 50, 13'h0777, 1'b0, 2);    // R4 saturation with overflow
        run_conv(0, 60, 100, 100, 13'h0123, 1'b0, 5);    // R5 clamp 0 -> 1, late change ignored
        run_conv(7, 37, 100, 100, 13'h1FFF, 1'b0, 1);    // R6 widest coarse, full fine
        run_conv(3, 55, 100, 100, 13'h0F0F, 1'b1, 3);    // R9 start during integration
        run_conv(4, 0, 100, 100, 13'h0000, 1'b0, 4);     // zero input

        check(q.size() == 0, "R8 all results seen", q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule